// File: doc/BRIEF.md
# Bus Wait Timeout Timer

This block is a watchdog for an I2C-style master engine. While the engine reports that it is held waiting on the bus, for example because a slave is stretching SCL, the block counts ticks of a slow time base. When the count reaches a programmed limit, it emits a one-cycle timeout pulse. The master status logic uses that pulse to set its timeout status flag. The time base is the input clock divided by a power of two. A small log2 code selects the power.

Software writes a 16-bit control word. The enable sits in the top bit and the limit sits in the low fifteen bits. Clearing only the enable bit stops the timer while the limit stays in place. Writing the enable back later resumes supervision with the same limit, so software can mask the watchdog around a command launch. Whenever the wait condition ends or the timer is disabled, the count returns to zero. The next wait episode is therefore timed from its own start.

The controller is a three-state machine:
- ST_IDLE: nothing is being timed.
- ST_COUNT: a wait episode is being timed.
- ST_EXPIRED: a timeout has already been reported for the current episode.

Its transitions are:
- ARM (ST_IDLE to ST_COUNT): enable set, wait asserted and limit nonzero.
- TICK (stay in ST_COUNT): a time-base tick below the limit.
- EXPIRE (ST_COUNT to ST_EXPIRED): the tick that makes the count reach the limit; this transition raises the pulse.
- ABORT (ST_COUNT to ST_IDLE): wait dropped, enable cleared or limit zeroed.
- RELEASE (ST_EXPIRED to ST_IDLE): wait dropped or enable cleared.

Top module: `bus_wait_timer`

## Requirements
- R1: After reset, `timeout_o` is 0 and the block is idle.
- R2: `ctrl_i[15]` is the enable and `ctrl_i[14:0]` is the limit. With the enable at 0, an asserted `wait_i` never produces a timeout.
- R3: `prescale_i` selects a time base of one tick per 2^p clocks, where p is `prescale_i`. Codes above 14 behave exactly like 14.
- R4: Let E0 be the first rising edge at which enable=1, limit L>0 and `wait_i`=1. Then `timeout_o` is 1 in the cycle after edge E0 + L·2^p, and 0 in every cycle before that.
- R5: The timeout pulse lasts exactly one cycle. While `wait_i` stays high after it, no further pulse occurs.
- R6: When `wait_i` drops, the count clears. A new assertion is timed from its own start, with no credit for the earlier episode.
- R7: Clearing only the enable bit stops the count and clears it, with no pulse. Setting the enable again with the limit unchanged times out after the full R4 interval, measured from the re-enable.
- R8: A limit of 0 never produces a timeout.
- R9: The largest limit, 32767, with p=0 times out exactly 32767 clocks after E0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| prescale_i | input | 4 | Log2 of the time-base division, 0 to 14 (larger values clamp to 14) |
| ctrl_i | input | 16 | Bit 15 is the enable; bits 14:0 are the limit in ticks |
| wait_i | input | 1 | High while the master engine is held waiting on the bus |
| timeout_o | output | 1 | One-cycle pulse when the limit is reached |

## Verification
The timeout pulse is registered. It is due in the cycle after edge E0 + L·2^p, where E0 is the first edge that samples the armed condition. The bench drives inputs at falling edges, so E0 is the first rising edge after `wait_i` is raised. It then counts rising edges until the pulse appears and compares the count with 1 + L·2^p. The sample taken one falling edge later must be low, which confirms the single-cycle width. Scenarios where no pulse is due watch the output at every falling edge over a window longer than any due time.

// File: rtl/bwt_pkg.sv
package bwt_pkg;
    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_COUNT   = 2'd1,
        ST_EXPIRED = 2'd2
    } bwt_state_e;
endpackage

// File: rtl/bwt_tick_gen.sv
// Power-of-two time base: emits one tick every 2^sel clocks, phase
// aligned to the cycle after clear_i is released.
module bwt_tick_gen #(
    parameter int PS_W     = 4,
    parameter int MAX_LOG2 = 14
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear_i,
    input  logic [PS_W-1:0] prescale_i,
    output logic            tick_o
);
    localparam int DIV_W = MAX_LOG2;
    localparam logic [PS_W-1:0] MAX_SEL = PS_W'(MAX_LOG2);

    logic [PS_W-1:0]  sel;
    logic [DIV_W-1:0] mask;
    logic [DIV_W-1:0] div_q;

    assign sel = (prescale_i > MAX_SEL) ? MAX_SEL : prescale_i;

    // Low 'sel' bits of the mask are set.
    for (genvar i = 0; i < DIV_W; i++) begin : g_mask
        assign mask[i] = (sel > PS_W'(i));
    end

    assign tick_o = ((div_q & mask) == mask);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            div_q <= '0;
        end else if (clear_i) begin
            div_q <= '0;
        end else begin
            div_q <= div_q + DIV_W'(1);
        end
    end
endmodule

// File: rtl/bwt_limit_counter.sv
// Tick counter with limit compare; hit_o flags the tick that reaches the limit.
module bwt_limit_counter #(
    parameter int LIMIT_W = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               clear_i,
    input  logic               tick_i,
    input  logic [LIMIT_W-1:0] limit_i,
    output logic               hit_o,
    output logic [LIMIT_W-1:0] count_o
);
    logic [LIMIT_W-1:0] cnt_q;
    logic [LIMIT_W:0]   cnt_next;

    assign cnt_next = {1'b0, cnt_q} + (LIMIT_W+1)'(1);
    assign hit_o    = tick_i && (cnt_next >= {1'b0, limit_i});
    assign count_o  = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (clear_i) begin
            cnt_q <= '0;
        end else if (tick_i && !hit_o) begin
            cnt_q <= cnt_next[LIMIT_W-1:0];
        end
    end
endmodule

// File: rtl/bus_wait_timer.sv
module bus_wait_timer #(
    parameter int LIMIT_W  = 15,
    parameter int PS_W     = 4,
    parameter int MAX_LOG2 = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [PS_W-1:0]  prescale_i,
    input  logic [LIMIT_W:0] ctrl_i,
    input  logic             wait_i,
    output logic             timeout_o
);
    import bwt_pkg::*;

    localparam int EN_BIT = LIMIT_W;

    bwt_state_e         state_q, state_d;
    logic               enable;
    logic [LIMIT_W-1:0] limit;
    logic               holding;
    logic               armed;
    logic               clear;
    logic               tick;
    logic               hit;
    logic [LIMIT_W-1:0] cnt_val;
    logic               timeout_q;

    assign enable  = ctrl_i[EN_BIT];
    assign limit   = ctrl_i[LIMIT_W-1:0];
    assign holding = enable && wait_i;
    assign armed   = holding && (limit != '0);
    assign clear   = (state_q != ST_COUNT) || !armed;

    bwt_tick_gen #(
        .PS_W     (PS_W),
        .MAX_LOG2 (MAX_LOG2)
    ) i_tick_gen (
        .clk        (clk),
        .rst_n      (rst_n),
        .clear_i    (clear),
        .prescale_i (prescale_i),
        .tick_o     (tick)
    );

    bwt_limit_counter #(
        .LIMIT_W (LIMIT_W)
    ) i_limit_counter (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (clear),
        .tick_i  (tick),
        .limit_i (limit),
        .hit_o   (hit),
        .count_o (cnt_val)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (armed) state_d = ST_COUNT;            // ARM
            end
            ST_COUNT: begin
                if (!armed)   state_d = ST_IDLE;          // ABORT
                else if (hit) state_d = ST_EXPIRED;       // EXPIRE
            end
            ST_EXPIRED: begin
                if (!holding) state_d = ST_IDLE;          // RELEASE
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Output register: pulse on the EXPIRE transition only
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) timeout_q <= 1'b0;
        else        timeout_q <= (state_q == ST_COUNT) && (state_d == ST_EXPIRED);
    end

    assign timeout_o = timeout_q;
endmodule

// File: rtl/bus_wait_timer_chk.sv
module bus_wait_timer_chk #(
    parameter int LIMIT_W = 15
) (
    input logic               clk,
    input logic               rst_n,
    input logic [LIMIT_W:0]   ctrl_i,
    input logic               wait_i,
    input logic               timeout_o,
    input logic [LIMIT_W-1:0] cnt_val
);
    // R5: a pulse never lasts two cycles
    p_single_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |=> !timeout_o);

    // R2: disabled timer never fires
    p_disabled_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !ctrl_i[LIMIT_W] |=> !timeout_o);

    // R8: zero limit never fires
    p_zero_limit_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_i[LIMIT_W-1:0] == '0) |=> !timeout_o);

    // R6: wait released clears the count
    p_release_clears_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_i |=> (cnt_val == '0));

    // R4: a pulse only follows a cycle with wait asserted
    p_fire_needs_wait_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !wait_i |=> !timeout_o);
endmodule

bind bus_wait_timer bus_wait_timer_chk #(.LIMIT_W(LIMIT_W)) i_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .ctrl_i    (ctrl_i),
    .wait_i    (wait_i),
    .timeout_o (timeout_o),
    .cnt_val   (cnt_val)
);

// File: tb/test_bus_wait_timer.sv
module test_bus_wait_timer;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [3:0]  prescale_i = '0;
    logic [15:0] ctrl_i = '0;
    logic        wait_i = 1'b0;
    logic        timeout_o;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    bus_wait_timer i_bus_wait_timer (
        .clk        (clk),
        .rst_n      (rst_n),
        .prescale_i (prescale_i),
        .ctrl_i     (ctrl_i),
        .wait_i     (wait_i),
        .timeout_o  (timeout_o)
    );

    task automatic check(input string req, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Count rising edges until a pulse is seen (0 if none within cap).
    task automatic run_until(input int cap, output int n);
        int k = 0;
        n = 0;
        while (k < cap) begin
            @(posedge clk); @(negedge clk);
            k++;
            if (timeout_o) begin
                n = k;
                break;
            end
        end
    endtask

    task automatic settle();
        @(negedge clk);
        wait_i = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_interval(input string req, input int p, input int lim, input int eff_p);
        int n;
        @(negedge clk);
        prescale_i = 4'(p);
        ctrl_i = {1'b1, 15'(lim)};
        @(negedge clk);
        wait_i = 1'b1;
        run_until((lim << eff_p) + 20, n);
        check(req, n, 1 + (lim << eff_p));
        @(posedge clk); @(negedge clk);
        check({req, " R5 width"}, int'(timeout_o), 0);
        settle();
    endtask

    task automatic t_reset();
        check("R1 reset", int'(timeout_o), 0);
    endtask

    task automatic t_disabled();
        int n;
        @(negedge clk);
        prescale_i = 0;
        ctrl_i = {1'b0, 15'd3};
        @(negedge clk);
        wait_i = 1'b1;
        run_until(50, n);
        check("R2 enable low", n, 0);
        settle();
    endtask

    task automatic t_single_pulse();
        int n;
        @(negedge clk);
        prescale_i = 0;
        ctrl_i = {1'b1, 15'd4};
        @(negedge clk);
        wait_i = 1'b1;
        run_until(30, n);
        check("R5 first pulse", n, 5);
        run_until(100, n);
        check("R5 no repeat while held", n, 0);
        settle();
        @(negedge clk);
        wait_i = 1'b1;
        run_until(30, n);
        check("R5 fires again next episode", n, 5);
        settle();
    endtask

    task automatic t_rearm();
        int n;
        @(negedge clk);
        prescale_i = 0;
        ctrl_i = {1'b1, 15'd5};
        @(negedge clk);
        wait_i = 1'b1;
        run_until(3, n);
        check("R6 partial episode quiet", n, 0);
        @(negedge clk);
        wait_i = 1'b0;
        @(negedge clk);
        wait_i = 1'b1;
        run_until(30, n);
        check("R6 fresh count", n, 6);
        settle();
    endtask

    task automatic t_enable_toggle();
        int n;
        @(negedge clk);
        prescale_i = 4'd1;
        ctrl_i = {1'b1, 15'd3};
        @(negedge clk);
        wait_i = 1'b1;
        run_until(4, n);
        check("R7 before drop", n, 0);
        @(negedge clk);
        ctrl_i = {1'b0, 15'd3};
        run_until(40, n);
        check("R7 stopped", n, 0);
        @(negedge clk);
        ctrl_i = {1'b1, 15'd3};
        run_until(40, n);
        check("R7 restored limit", n, 7);
        settle();
    endtask

    task automatic t_zero_limit();
        int n;
        @(negedge clk);
        prescale_i = 0;
        ctrl_i = {1'b1, 15'd0};
        @(negedge clk);
        wait_i = 1'b1;
        run_until(200, n);
        check("R8 zero limit", n, 0);
        settle();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_interval("R4 p0 L5", 0, 5, 0);
        t_interval("R4 p0 L1", 0, 1, 0);
        t_interval("R3 p3 L4", 3, 4, 3);
        t_interval("R3 p14 L1", 14, 1, 14);
        t_interval("R3 clamp p15 L1", 15, 1, 14);
        t_disabled();
        t_single_pulse();
        t_rearm();
        t_enable_toggle();
        t_zero_limit();
        t_interval("R9 max limit", 0, 32767, 0);
        if (!done) begin
            done = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
            $finish;
        end
    end
endmodule